// File: doc/BRIEF.md
# Duty-cycled receive power sequencer

This block runs a receiver in a power-saving duty cycle. When the duty mode is on, it steps through four named timed or waiting phases: an off phase with every receiver module unpowered, a wake phase in which it pulls a shared, externally pulled-up line low to rouse a sleeping host, a settle phase in which the configured modules are powered so the RF path can stabilise, and a hold phase in which the demodulated data outputs are enabled. The host keeps the receiver in the hold phase by driving the shared line low itself. When the host lets the line go high, the off phase starts again.

The states are WAIT (idle, sequence armed), OFF, WAKE, SETTLE and HOLD. The transitions are as follows. WAIT goes to OFF when chip-select and the line are both high at a clock edge. OFF goes to WAKE when the off timer expires. WAKE goes to SETTLE when the wake timer expires. SETTLE goes to HOLD when the settle timer expires, and at that point the pull-low drive is released. HOLD goes to OFF when the line reads high. Any state goes to WAIT whenever chip-select is low, the duty mode is off, or sleep is requested. A single down-counter serves all three timers. It is reloaded from the reload value for each phase on entry and counts only on cycles where the shared `tick` input is high. Calibrating the tick is left to the surrounding logic.

With the duty mode off, the module power enables follow the power configuration input directly. The sleep request overrides everything else and darkens all outputs.

Top module: `rxduty_seq`

## Requirements
- R1: While reset is asserted and after its release, the sequencer is in WAIT. With duty mode on, `pwr_en` is 0, `line_pull_low` is 0 and `dout_en` is 0.
- R2: `sleep_req`=1 forces `pwr_en`=0, `line_pull_low`=0 and `dout_en`=0 in the same cycle, whatever the mode or state. The sequencer is in WAIT at the next edge.
- R3: With `duty_mode`=0 and `sleep_req`=0, `pwr_en` equals `pwr_cfg`, `line_pull_low`=0 and `dout_en`=1, combinationally.
- R4: In WAIT, the sequence moves to OFF at the first edge that sees `cs`=1 and `line_in`=1. While either one is low, it stays in WAIT.
- R5: OFF lasts max(`off_reload`,1) tick cycles, with `pwr_en`=0, `line_pull_low`=0 and `dout_en`=0.
- R6: WAKE lasts max(`cpu_reload`,1) tick cycles, with `line_pull_low`=1, `pwr_en`=0 and `dout_en`=0.
- R7: SETTLE lasts max(`rf_reload`,1) tick cycles, with `line_pull_low`=1, `pwr_en`=`pwr_cfg` and `dout_en`=0. It is entered only from WAKE.
- R8: On SETTLE expiry, HOLD is entered: `line_pull_low`=0, `pwr_en`=`pwr_cfg` and `dout_en`=1. HOLD lasts as long as `line_in` reads low.
- R9: When `line_in` reads high in HOLD, OFF is re-entered at the next edge with the off timer reloaded.
- R10: If the host has not taken the line low when the pull-low drive is released, HOLD lasts exactly one cycle and OFF follows.
- R11: `cs`=0 at an edge returns the sequencer to WAIT, and the outputs go to 0.
- R12: The timers advance only on cycles with `tick`=1. Without ticks, a timed phase never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_mode | input | 1 | 1 selects the duty-cycled sequence |
| sleep_req | input | 1 | Deep-sleep override |
| pwr_cfg | input | PW | Module power configuration |
| cs | input | 1 | Chip-select; high arms the sequence |
| line_in | input | 1 | Sensed level of the shared pulled-up line |
| tick | input | 1 | Timer tick strobe |
| off_reload | input | TW | OFF phase length in ticks |
| cpu_reload | input | TW | WAKE phase length in ticks |
| rf_reload | input | TW | SETTLE phase length in ticks |
| pwr_en | output | PW | Module power enables |
| line_pull_low | output | 1 | Drive that pulls the shared line low |
| dout_en | output | 1 | Data output enable |

## Verification
The outputs are combinational from the registered state and from the mode, sleep and configuration inputs. The sleep and direct-mode results are therefore due in the same cycle as the stimulus. A state change is due one edge after the condition that causes it. With a tick on every cycle, a phase loaded with reload N is visible for exactly max(N,1) samples. The bench drives inputs and samples outputs on the falling edge. It computes the expected phase of every sample from the cycle count since the start edge, and it sweeps all reload combinations from 0 to 3, with and without a host taking over the line.

// File: rtl/rxduty_pkg.sv
package rxduty_pkg;
    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_OFF    = 3'd1,
        ST_WAKE   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_HOLD   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rxduty_timer.sv
module rxduty_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    // a reload of 0 behaves as 1 tick
    assign expire = tick && (cnt <= ONE);
endmodule

// File: rtl/rxduty_ctrl.sv
module rxduty_ctrl
    import rxduty_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          duty_mode,
    input  logic          sleep_req,
    input  logic          cs,
    input  logic          line_in,
    input  logic          expire,
    input  logic [TW-1:0] off_reload,
    input  logic [TW-1:0] cpu_reload,
    input  logic [TW-1:0] rf_reload,
    output seq_state_e    st,
    output logic          load,
    output logic [TW-1:0] load_val
);
    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_WAIT;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = off_reload;
        if (!duty_mode || sleep_req || !cs) begin
            nxt = ST_WAIT;
        end else begin
            unique case (st)
                ST_WAIT: if (line_in) begin
                    nxt = ST_OFF;  load = 1'b1; load_val = off_reload;
                end
                ST_OFF: if (expire) begin
                    nxt = ST_WAKE; load = 1'b1; load_val = cpu_reload;
                end
                ST_WAKE: if (expire) begin
                    nxt = ST_SETTLE; load = 1'b1; load_val = rf_reload;
                end
                ST_SETTLE: if (expire) begin
                    nxt = ST_HOLD;
                end
                ST_HOLD: if (line_in) begin
                    nxt = ST_OFF;  load = 1'b1; load_val = off_reload;
                end
                default: nxt = ST_WAIT;
            endcase
        end
    end

    // R11: chip-select low returns the sequencer to WAIT
    a_r11_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> st == ST_WAIT);

    // R9: line released in HOLD restarts the off phase
    a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && line_in && cs && duty_mode && !sleep_req) |=> st == ST_OFF);

    // R7: SETTLE is only reached from WAKE
    a_r7_settle_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> ($past(st) == ST_WAKE || $past(st) == ST_SETTLE));
endmodule

// File: rtl/rxduty_outmux.sv
module rxduty_outmux
    import rxduty_pkg::*;
#(
    parameter int PW = 7
) (
    input  seq_state_e    st,
    input  logic          duty_mode,
    input  logic          sleep_req,
    input  logic [PW-1:0] pwr_cfg,
    output logic [PW-1:0] pwr_en,
    output logic          line_pull_low,
    output logic          dout_en
);
    always_comb begin
        pwr_en        = '0;
        line_pull_low = 1'b0;
        dout_en       = 1'b0;
        if (sleep_req) begin
            pwr_en = '0;
        end else if (!duty_mode) begin
            pwr_en  = pwr_cfg;
            dout_en = 1'b1;
        end else begin
            unique case (st)
                ST_WAIT, ST_OFF: ;
                ST_WAKE:   line_pull_low = 1'b1;
                ST_SETTLE: begin
                    line_pull_low = 1'b1;
                    pwr_en        = pwr_cfg;
                end
                ST_HOLD: begin
                    pwr_en  = pwr_cfg;
                    dout_en = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxduty_seq.sv
module rxduty_seq
    import rxduty_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          duty_mode,
    input  logic          sleep_req,
    input  logic [PW-1:0] pwr_cfg,
    input  logic          cs,
    input  logic          line_in,
    input  logic          tick,
    input  logic [TW-1:0] off_reload,
    input  logic [TW-1:0] cpu_reload,
    input  logic [TW-1:0] rf_reload,
    output logic [PW-1:0] pwr_en,
    output logic          line_pull_low,
    output logic          dout_en
);
    seq_state_e    st;
    logic          load;
    logic [TW-1:0] load_val;
    logic          expire;

    rxduty_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(tick), .expire(expire)
    );

    rxduty_ctrl #(.TW(TW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .duty_mode(duty_mode), .sleep_req(sleep_req),
        .cs(cs), .line_in(line_in), .expire(expire),
        .off_reload(off_reload), .cpu_reload(cpu_reload), .rf_reload(rf_reload),
        .st(st), .load(load), .load_val(load_val)
    );

    rxduty_outmux #(.PW(PW)) u_outmux (
        .st(st), .duty_mode(duty_mode), .sleep_req(sleep_req), .pwr_cfg(pwr_cfg),
        .pwr_en(pwr_en), .line_pull_low(line_pull_low), .dout_en(dout_en)
    );

    // R2: sleep darkens every output
    a_r2_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (pwr_en == '0 && !line_pull_low && !dout_en));

    // R8: in duty mode the data outputs are enabled only in HOLD
    a_r8_dout_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_mode && !sleep_req && dout_en) |-> st == ST_HOLD);

    // R12: without a tick a timed phase does not advance
    a_r12_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OFF || st == ST_WAKE || st == ST_SETTLE) && !tick
         && cs && duty_mode && !sleep_req) |=> $stable(st));
endmodule

// File: tb/rxduty_seq_bench.sv
module rxduty_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    localparam int PW = 7;
    localparam logic [PW-1:0] CFG = 7'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          duty_mode = 1'b1;
    logic          sleep_req = 1'b0;
    logic [PW-1:0] pwr_cfg = CFG;
    logic          cs = 1'b0;
    logic          host_low = 1'b0;
    logic          line_in;
    logic          tick = 1'b1;
    logic [TW-1:0] off_reload = '0;
    logic [TW-1:0] cpu_reload = '0;
    logic [TW-1:0] rf_reload = '0;
    logic [PW-1:0] pwr_en;
    logic          line_pull_low;
    logic          dout_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // shared line: pulled up unless the block or the host pulls it low
    assign line_in = !(line_pull_low || host_low);

    rxduty_seq #(.TW(TW), .PW(PW)) u_rxduty_seq (
        .clk(clk), .rst_n(rst_n), .duty_mode(duty_mode), .sleep_req(sleep_req),
        .pwr_cfg(pwr_cfg), .cs(cs), .line_in(line_in), .tick(tick),
        .off_reload(off_reload), .cpu_reload(cpu_reload), .rf_reload(rf_reload),
        .pwr_en(pwr_en), .line_pull_low(line_pull_low), .dout_en(dout_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [PW-1:0] ep, logic epl, logic ed);
        n_tests++;
        if (pwr_en !== ep || line_pull_low !== epl || dout_en !== ed) begin
            n_fail++;
            $display("FAIL %s pwr_en=%h exp %h pull=%b exp %b dout=%b exp %b",
                     tag, pwr_en, ep, line_pull_low, epl, dout_en, ed);
        end
    endtask

    // phase 0 OFF, 1 WAKE, 2 SETTLE, 3 HOLD
    task automatic chk_phase(string tag, int ph);
        case (ph)
            0: chk(tag, '0, 1'b0, 1'b0);
            1: chk(tag, '0, 1'b1, 1'b0);
            2: chk(tag, CFG, 1'b1, 1'b0);
            default: chk(tag, CFG, 1'b0, 1'b1);
        endcase
    endtask

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_seq(int o, int c, int r, bit host);
        int eo, ec, er;
        eo = eff(o); ec = eff(c); er = eff(r);
        cs = 1'b0; host_low = 1'b0;
        step();
        off_reload = TW'(o); cpu_reload = TW'(c); rf_reload = TW'(r);
        cs = 1'b1;
        step();
        for (int j = 0; j < eo + ec + er; j++) begin
            if (j < eo)            chk_phase("R5", 0);
            else if (j < eo + ec)  chk_phase("R6", 1);
            else                   chk_phase("R7", 2);
            if (host && j >= eo) host_low = 1'b1;
            step();
        end
        if (host) begin
            for (int k = 0; k < 3; k++) begin
                chk_phase("R8", 3);
                if (k == 2) host_low = 1'b0;
                step();
            end
            for (int k = 0; k <= eo; k++) begin
                chk_phase("R9", (k < eo) ? 0 : 1);
                step();
            end
        end else begin
            chk_phase("R10", 3);
            step();
            for (int k = 0; k <= eo; k++) begin
                chk_phase("R10", (k < eo) ? 0 : 1);
                step();
            end
        end
        cs = 1'b0;
        step();
        chk("R11", '0, 1'b0, 1'b0);
        host_low = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1", '0, 1'b0, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        chk("R1", '0, 1'b0, 1'b0);

        // R3: direct power in continuous mode
        duty_mode = 1'b0;
        for (int p = 0; p < 128; p += 19) begin
            pwr_cfg = PW'(p);
            cs = p[0];
            #1;
            chk("R3", PW'(p), 1'b0, 1'b1);
            step();
        end
        // R2: sleep overrides direct mode
        pwr_cfg = 7'h7F; sleep_req = 1'b1;
        #1;
        chk("R2", '0, 1'b0, 1'b0);
        step();
        sleep_req = 1'b0; pwr_cfg = CFG; duty_mode = 1'b1; cs = 1'b0;
        step();

        // R4..R11: sweep of reload values, with and without host takeover
        for (int o = 0; o < 4; o++)
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    for (int h = 0; h < 2; h++)
                        run_seq(o, c, r, h[0]);

        // R2: sleep mid-sequence, then R4: WAIT holds while line is low
        off_reload = 8'd2; cpu_reload = 8'd2; rf_reload = 8'd1;
        cs = 1'b1;
        step();                       // OFF
        step(); step();               // WAKE
        host_low = 1'b1;
        step(); step(); step();       // SETTLE then HOLD
        chk("R8", CFG, 1'b0, 1'b1);
        sleep_req = 1'b1;
        #1;
        chk("R2", '0, 1'b0, 1'b0);
        step();
        sleep_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk("R4", '0, 1'b0, 1'b0);
            step();
        end
        host_low = 1'b0;
        step();                       // start edge -> OFF
        chk_phase("R4", 0);
        step();
        chk_phase("R4", 0);
        step();
        chk_phase("R4", 1);
        cs = 1'b0;
        step();
        chk("R11", '0, 1'b0, 1'b0);

        // R12: no tick, no progress
        off_reload = 8'd3; tick = 1'b0; cs = 1'b1;
        step();
        for (int k = 0; k < 40; k++) begin
            chk_phase("R12", 0);
            step();
        end
        tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk_phase("R12", (k < 3) ? 0 : 1);
            step();
        end
        cs = 1'b0;
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule